// File: doc/BRIEF.md
# Prescaled Auto-Reload Countdown Timer

The block is a single down-counting timer behind a small word-addressed register window. Software sets a reload value, picks a clock divide ratio and a run mode, and turns the timer on. The count then steps down once per divided clock period. When it runs out, the block sets a sticky flag and drives its level interrupt from that flag. In periodic mode it refills the count from the reload value and keeps going. In one-shot mode it parks at zero.

All accesses are full 32-bit words. The read data path is combinational from the address, and a write takes effect at the rising clock edge where `reg_wr` is high. The interrupt line is a direct copy of the status flag. Software acknowledges the interrupt by writing a one to the flag.

Top module: `ptmr_timer`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), the load, count, control and status registers are all zero, so every register reads 0 and irq is low.
- R2: Word offsets within the 32-byte window: load 0x00, counter 0x04, control 0x08, status 0x0C. Any other offset, including one with address bits 1:0 non-zero, reads 0, and writes to it change nothing.
- R3: Control word fields: bit 0 = run enable, bit 1 = periodic (auto-reload), bits 15:8 = prescale P. While running, the count drops by one every P+1 clock cycles. A count of N that was just written, or just enabled, therefore expires exactly N*(P+1) cycles later, because the divider restarts on every count write and on every enable.
- R4: At expiry the status flag (bit 0 of the status word) becomes 1. In periodic mode, the count is refilled from the load value in the same cycle and counting continues.
- R5: At expiry in one-shot mode, the count becomes 0 and stays at 0. The status flag stays set until software clears it.
- R6: A write to the load register sets both the load value and the live count. A write to the counter register sets only the live count.
- R7: When a control write turns the enable bit from 0 to 1 while the count is zero and the written periodic bit is 1, the count is first fetched from the load value.
- R8: While the count is zero, no countdown runs and no expiry occurs.
- R9: The counter register reads 0 while the timer is disabled or the count is zero. Otherwise it reads the live remaining count.
- R10: Writing the status register with bit 0 = 1 clears the flag, and writing 0 leaves it unchanged. irq always equals the flag.
- R11: If an expiry and a status clear fall on the same clock edge, the expiry wins and the flag stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_addr | input | 5 | Byte offset within the register window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| irq | output | 1 | Level interrupt, equal to the status flag |

## Verification
Some properties are checked on every cycle. Expiry always raises the flag on the next edge, even against a clear in the same cycle. The flag never rises without an expiry. The count never climbs except through a write or a reload. A disabled or zero count stays frozen. A one-shot expiry parks at zero. A disabled or empty counter reads zero.

Other behaviours need the bench's scenarios to show them. These are the exact expiry latency N*(P+1) across several prescale and count values, the reload value seen after a periodic expiry, fetching the load value on enable, and the separation between load writes and counter writes. The bench also shows the write-one-to-clear semantics and that unmapped offsets have no effect.

// File: rtl/ptmr_pkg.sv
// Package: shared constants for the countdown timer.
// Assumes a 32-byte register window addressed in whole 32-bit words.
package ptmr_pkg;
    localparam int DATA_W  = 32;
    localparam int WIN_AW  = 5;
    localparam int WORD_AW = WIN_AW - 2;

    // Word index inside the window; the order sets the offsets.
    typedef enum logic [WORD_AW-1:0] {
        WORD_LOAD  = 3'd0,
        WORD_COUNT = 3'd1,
        WORD_CTRL  = 3'd2,
        WORD_STAT  = 3'd3
    } word_e;

    localparam int CTL_EN_BIT  = 0;
    localparam int CTL_PER_BIT = 1;
    localparam int CTL_PRE_LSB = 8;
endpackage

// File: rtl/ptmr_prescaler.sv
// Module: divides the base clock by (div_val+1) into single-cycle ticks.
// Assumes restart is pulsed whenever the count is rewritten or enabled.
module ptmr_prescaler #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [PRE_W-1:0] div_val,
    output logic             tick
);
    logic [PRE_W-1:0] div_q;

    assign tick = run && !restart && (div_q == div_val);

    // Purpose: step the divider phase, clearing it on restart or idle.
    always_ff @(posedge clk) begin
        if (!rst_n)                  div_q <= '0;
        else if (restart || !run)    div_q <= '0;
        else if (div_q == div_val)   div_q <= '0;
        else                         div_q <= div_q + 1'b1;
    end
endmodule

// File: rtl/ptmr_count.sv
// Module: live down-counter with expiry detection and reload.
// Assumes tick only arrives while the count is non-zero.
module ptmr_count #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             periodic,
    input  logic [CNT_W-1:0] load_val,
    input  logic             wr_cnt,
    input  logic [CNT_W-1:0] wr_val,
    input  logic             fetch,
    output logic [CNT_W-1:0] cnt,
    output logic             expire
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    assign cnt    = cnt_q;
    assign expire = tick && (cnt_q == ONE);

    // Purpose: apply software writes first, then fetch, reload or decrement.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt_q <= '0;
        else if (wr_cnt)   cnt_q <= wr_val;
        else if (fetch)    cnt_q <= load_val;
        else if (expire)   cnt_q <= periodic ? load_val : '0;
        else if (tick)     cnt_q <= cnt_q - ONE;
    end
endmodule

// File: rtl/ptmr_regs.sv
// Module: load, control and status registers plus write decode.
// Assumes word_idx is already masked to mapped offsets by the caller.
module ptmr_regs
    import ptmr_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int PRE_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic               hit,
    input  word_e              word_idx,
    input  logic [CNT_W-1:0]   w_cnt,
    input  logic               w_bit0,
    input  logic               w_bit1,
    input  logic [PRE_W-1:0]   w_pre,
    input  logic               expire,
    input  logic               cnt_zero,
    output logic [CNT_W-1:0]   load_q,
    output logic               en_q,
    output logic               per_q,
    output logic [PRE_W-1:0]   pre_q,
    output logic               stat_q,
    output logic               wr_cnt,
    output logic               fetch,
    output logic               restart
);
    logic wr_load, wr_ctrl, wr_stat, en_rise;

    assign wr_load = reg_wr && hit && (word_idx == WORD_LOAD);
    assign wr_ctrl = reg_wr && hit && (word_idx == WORD_CTRL);
    assign wr_stat = reg_wr && hit && (word_idx == WORD_STAT);
    assign wr_cnt  = wr_load || (reg_wr && hit && (word_idx == WORD_COUNT));
    assign en_rise = wr_ctrl && w_bit0 && !en_q;
    assign fetch   = en_rise && cnt_zero && w_bit1;
    assign restart = wr_cnt || en_rise;

    // Purpose: hold the reload value.
    always_ff @(posedge clk) begin
        if (!rst_n)       load_q <= '0;
        else if (wr_load) load_q <= w_cnt;
    end

    // Purpose: hold the control fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            per_q <= 1'b0;
            pre_q <= '0;
        end else if (wr_ctrl) begin
            en_q  <= w_bit0;
            per_q <= w_bit1;
            pre_q <= w_pre;
        end
    end

    // Purpose: sticky flag; expiry has priority over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                 stat_q <= 1'b0;
        else if (expire)            stat_q <= 1'b1;
        else if (wr_stat && w_bit0) stat_q <= 1'b0;
    end
endmodule

// File: rtl/ptmr_timer.sv
// Module: top of the prescaled countdown timer with register window.
// Assumes full-word accesses; reads are combinational from reg_addr.
module ptmr_timer
    import ptmr_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int PRE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [WIN_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);
    logic             hit;
    word_e            word_idx;
    logic [CNT_W-1:0] load_q, cnt_q;
    logic             en_q, per_q, stat_q;
    logic [PRE_W-1:0] pre_q;
    logic             wr_cnt, fetch, restart, tick, expire, run, cnt_zero;

    assign word_idx = word_e'(reg_addr[WIN_AW-1:2]);
    assign hit      = (reg_addr[1:0] == 2'b00) && (reg_addr[WIN_AW-1:2] < 3'd4);
    assign cnt_zero = (cnt_q == '0);
    assign run      = en_q && !cnt_zero;
    assign irq      = stat_q;

    ptmr_regs #(.CNT_W(CNT_W), .PRE_W(PRE_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .hit(hit),
        .word_idx(word_idx), .w_cnt(reg_wdata[CNT_W-1:0]),
        .w_bit0(reg_wdata[CTL_EN_BIT]), .w_bit1(reg_wdata[CTL_PER_BIT]),
        .w_pre(reg_wdata[CTL_PRE_LSB +: PRE_W]),
        .expire(expire), .cnt_zero(cnt_zero),
        .load_q(load_q), .en_q(en_q), .per_q(per_q), .pre_q(pre_q),
        .stat_q(stat_q), .wr_cnt(wr_cnt), .fetch(fetch), .restart(restart)
    );

    ptmr_prescaler #(.PRE_W(PRE_W)) pre_i (
        .clk(clk), .rst_n(rst_n), .run(run), .restart(restart),
        .div_val(pre_q), .tick(tick)
    );

    ptmr_count #(.CNT_W(CNT_W)) cnt_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .periodic(per_q),
        .load_val(load_q), .wr_cnt(wr_cnt), .wr_val(reg_wdata[CNT_W-1:0]),
        .fetch(fetch), .cnt(cnt_q), .expire(expire)
    );

    // Purpose: select read data for the addressed word.
    always_comb begin
        reg_rdata = '0;
        if (hit) begin
            unique case (word_idx)
                WORD_LOAD:  reg_rdata = DATA_W'(load_q);
                WORD_COUNT: reg_rdata = run ? DATA_W'(cnt_q) : '0;
                WORD_CTRL: begin
                    reg_rdata[CTL_EN_BIT]                = en_q;
                    reg_rdata[CTL_PER_BIT]               = per_q;
                    reg_rdata[CTL_PRE_LSB +: PRE_W]      = pre_q;
                end
                WORD_STAT:  reg_rdata[0] = stat_q;
                default:    reg_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/ptmr_checker.sv
// Module: cycle-level properties of the timer, bound into ptmr_timer.
// Assumes it observes the live count and expiry strobe from inside the top.
module ptmr_checker #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic [2:0]       word,
    input logic             lowbits_zero,
    input logic             clr_bit,
    input logic [31:0]      reg_rdata,
    input logic             irq,
    input logic [CNT_W-1:0] cnt,
    input logic             expire,
    input logic             en,
    input logic             per
);
    logic stat_clr;
    assign stat_clr = reg_wr && lowbits_zero && (word == 3'd3) && clr_bit;

    assert_expire_sets_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> irq);

    assert_flag_beats_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && stat_clr) |=> irq);

    assert_flag_needs_expiry_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(expire));

    assert_count_never_climbs_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_wr && !expire) |=> (cnt <= $past(cnt)));

    assert_idle_count_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_wr && (!en || cnt == '0)) |=> $stable(cnt));

    assert_oneshot_parks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !per && !reg_wr) |=> (cnt == '0));

    assert_counter_read_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (lowbits_zero && word == 3'd1 && (!en || cnt == '0)) |-> (reg_rdata == '0));
endmodule

bind ptmr_timer ptmr_checker #(.CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .word(reg_addr[4:2]),
    .lowbits_zero(reg_addr[1:0] == 2'b00), .clr_bit(reg_wdata[0]),
    .reg_rdata(reg_rdata), .irq(irq), .cnt(cnt_q), .expire(expire),
    .en(en_q), .per(per_q)
);

// File: tb/ptmr_timer_tb_top.sv
module ptmr_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    localparam logic [4:0] A_LOAD = 5'h00, A_CNT = 5'h04, A_CTL = 5'h08,
                           A_STAT = 5'h0C, A_GAP = 5'h10;

    // {prescale[47:40], count[39:8], periodic[0]}
    localparam int NV = 6;
    localparam logic [47:0] VEC [NV] = '{
        {8'd0, 32'd1,  8'd0},
        {8'd0, 32'd5,  8'd1},
        {8'd3, 32'd4,  8'd0},
        {8'd2, 32'd7,  8'd1},
        {8'd7, 32'd3,  8'd1},
        {8'd1, 32'd10, 8'd0}
    };

    ptmr_timer dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%0d expected=%0d", req, got, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic wait_neg(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #1500000;
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        wait_neg(3);
        rst_n = 1'b1;
        wait_neg(1);

        // R1 reset state
        rd(A_LOAD, v); check("R1 load", v, 0);
        rd(A_CNT,  v); check("R1 count", v, 0);
        rd(A_CTL,  v); check("R1 ctrl", v, 0);
        rd(A_STAT, v); check("R1 status", v, 0);
        check("R1 irq", {31'd0, irq}, 0);

        // R3 R4 R5: vector table of prescale / count / mode
        for (int k = 0; k < NV; k++) begin
            logic [7:0]  p;
            logic [31:0] n;
            logic        per;
            int          cyc;
            p = VEC[k][47:40]; n = VEC[k][39:8]; per = VEC[k][0];
            wr(A_CTL, 0);
            wr(A_STAT, 1);
            wr(A_LOAD, n);
            wr(A_CTL, {16'd0, p, 6'd0, per, 1'b1});
            cyc = 0;
            while (!irq && cyc < 5000) begin
                @(negedge clk); cyc++;
            end
            check("R3 expiry latency", cyc, n * (p + 1));
            rd(A_CNT, v);
            check(per ? "R4 reload value" : "R5 parked at zero", v, per ? n : 0);
        end

        // R5 one-shot stays at zero, flag sticky
        wr(A_CTL, 0); wr(A_STAT, 1);
        wr(A_LOAD, 2); wr(A_CTL, 1);
        wait_neg(12);
        rd(A_CNT, v); check("R5 stays zero", v, 0);
        check("R5 flag sticky", {31'd0, irq}, 1);

        // R10 writing zero leaves flag; writing one clears it
        wr(A_STAT, 0);
        check("R10 zero write keeps flag", {31'd0, irq}, 1);
        wr(A_STAT, 1);
        check("R10 one write clears flag", {31'd0, irq}, 0);

        // R9 R6 disabled counter reads zero; load write sets load
        wr(A_CTL, 0);
        wr(A_LOAD, 9);
        rd(A_CNT, v);  check("R9 disabled reads zero", v, 0);
        rd(A_LOAD, v); check("R6 load value", v, 9);

        // R6 counter write changes count only
        wr(A_CNT, 20);
        rd(A_LOAD, v); check("R6 counter write keeps load", v, 9);
        wr(A_CTL, 1);
        rd(A_CNT, v); check("R6 counter write sets count", v, 20);
        wait_neg(3);
        rd(A_CNT, v); check("R9 live count", v, 17);

        // R7 enable with zero count and periodic set fetches load
        wr(A_CTL, 0);
        wr(A_CNT, 0);
        wr(A_CTL, 3);
        rd(A_CNT, v); check("R7 fetch on enable", v, 9);
        wait_neg(3);
        rd(A_CNT, v); check("R7 counting from fetched value", v, 6);

        // R8 zero count without periodic: nothing happens
        wr(A_CTL, 0); wr(A_STAT, 1);
        wr(A_CNT, 0);
        wr(A_CTL, 1);
        wait_neg(20);
        check("R8 no expiry at zero", {31'd0, irq}, 0);
        rd(A_CNT, v); check("R8 zero count reads zero", v, 0);

        // R2 unmapped offsets read zero and ignore writes
        wr(A_GAP, 32'h55);
        rd(A_GAP, v);  check("R2 gap reads zero", v, 0);
        wr(5'h01, 32'h77);
        rd(A_LOAD, v); check("R2 unmapped writes ignored", v, 9);
        rd(5'h01, v);  check("R2 misaligned reads zero", v, 0);

        // R11 expiry and clear on the same edge
        wr(A_CTL, 0); wr(A_STAT, 1);
        wr(A_LOAD, 3);
        wr(A_CTL, 1);
        wait_neg(2);
        wr(A_STAT, 1);
        check("R11 expiry beats clear", {31'd0, irq}, 1);

        // R1 reset mid-run
        wr(A_LOAD, 50); wr(A_CTL, 3);
        rst_n = 1'b0; wait_neg(2); rst_n = 1'b1; wait_neg(1);
        rd(A_LOAD, v); check("R1 reset clears load", v, 0);
        rd(A_CTL, v);  check("R1 reset clears ctrl", v, 0);
        check("R1 reset clears irq", {31'd0, irq}, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule